// File: doc/BRIEF.md
# Packet Timestamp Capture Slots

This block holds the timestamps of timing-event packets. A free-running 64-bit nanosecond count is sampled whenever a transmit or receive event strobe arrives. One register holds the transmit capture. A small pool of receive slots holds the receive captures. Each captured value stays locked until software reads its high word. Reading the high word frees the register for the next event. Reading the low word first and the high word afterwards therefore always returns one coherent 64-bit value, however far the clock has moved in between.

On a receive event, the block grants the lowest-numbered free slot. It reports that slot's index in the same cycle, so the packet path can carry the index to software. When every slot is occupied, the event receives the invalid index and a saturating drop counter increments. A transmit event that arrives while the transmit register is still locked is discarded. An interrupt, gated by an enable input, stays high for as long as a transmit capture waits to be read. Software reads everything through one word-wide read port. A read-only status word collects the valid flags and the drop count.

Top module: `ts_capture_slots`

## Requirements
- R1: After a synchronous active-low reset, all receive valid flags, the transmit valid flag, the drop count and `tx_irq` are 0, and the status word (address 2) reads 0.
- R2: On a receive event, the lowest-numbered free slot is granted. Its index appears on `rx_slot_idx`, with `rx_idx_valid`=1, in the same cycle. The slot latches the `time_ns` value present in that cycle, and its valid flag is 1 from the next cycle.
- R3: The status word carries the receive valid flags in bits [3:0] (bit i for slot i), the transmit valid flag in bit 8 and the drop count in bits [23:16].
- R4: A read of the high word of receive slot i (address 5+2i) clears that slot's valid flag from the next cycle. A read of its low word (address 4+2i) leaves the flag set.
- R5: A receive event with all slots occupied reports `rx_slot_idx`=7 with `rx_idx_valid`=0, changes no slot, and increments the drop count. The drop count saturates at 255.
- R6: A transmit event with the transmit register free latches `time_ns` and sets the transmit valid flag from the next cycle.
- R7: A transmit event while the transmit valid flag is set is ignored. The held value is kept.
- R8: A read of the transmit high word (address 1) clears the transmit valid flag from the next cycle. A read of the transmit low word (address 0) leaves it set.
- R9: `tx_irq` is 1 exactly when `irq_en` is 1 and the transmit valid flag is set.
- R10: The low word (addresses 0 or 4+2i) followed later by the high word (addresses 1 or 5+2i) together return the 64-bit value captured at the event.
- R11: Reading the status word changes no valid flag.
- R12: When a slot's high-word read and a receive event fall in the same cycle, the event sees the occupancy before the release. With all slots occupied, the event is dropped, and the slot is free from the next cycle.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_ns | input | 64 | Running nanosecond time |
| tx_event | input | 1 | Transmit timing-event strobe |
| rx_event | input | 1 | Receive timing-event strobe |
| irq_en | input | 1 | Transmit capture interrupt enable |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data, same cycle as `rd_en`; 0 when idle |
| rx_slot_idx | output | 3 | Granted slot index, 7 when invalid or idle |
| rx_idx_valid | output | 1 | A slot was granted this cycle |
| tx_irq | output | 1 | Transmit capture interrupt |
| rx_status | output | 4 | Receive slot valid flags |
| tx_status | output | 1 | Transmit register valid flag |
| drop_count | output | 8 | Saturating count of dropped receive events |

## Verification
Two functions can meet in the same cycle: releasing a slot through a high-word read, and allocating a slot to a receive event. The bench fills every slot, then raises a receive event and the high-word read of slot 2 in the same cycle. It expects the invalid index and one more drop in that cycle, and slot 2 free in the next cycle. A further event must then receive index 2. The same ordering holds on the transmit side: a second transmit event held back by a locked register must not disturb the value that the following high read returns.

// File: rtl/ts_cap_pkg.sv
`timescale 1ns/1ps
// Package: shared read-map and status-word layout for the capture block.
// Assumes the time value is exactly two read words wide.
package ts_cap_pkg;

    // Fixed read addresses of the transmit register and status word
    localparam int ADDR_TX_LO  = 0;
    localparam int ADDR_TX_HI  = 1;
    localparam int ADDR_STATUS = 2;
    localparam int ADDR_RX0    = 4;

    // Status word bit positions
    localparam int STAT_TX_BIT   = 8;
    localparam int STAT_DROP_LSB = 16;

    // Low-word address of receive slot i
    function automatic int rx_lo_addr(input int i);
        return ADDR_RX0 + 2 * i;
    endfunction

    // High-word address of receive slot i (the read that unlocks it)
    function automatic int rx_hi_addr(input int i);
        return ADDR_RX0 + 2 * i + 1;
    endfunction

endpackage

// File: rtl/ts_slot.sv
`timescale 1ns/1ps
// Module: one lock-until-read timestamp register.
// A capture is accepted only while the register is free; a release frees it.
// Release wins over capture in the same cycle because a locked register
// never accepts a capture. Callers must gate capture with their own grant.
module ts_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              rel_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              valid_o,
    output logic [TIME_W-1:0] value_o
);

    logic              valid_q;
    logic [TIME_W-1:0] value_q;

    // Lock state and held value: free on release, latch on capture when free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            value_q <= '0;
        end else if (valid_q) begin
            if (rel_i) begin
                valid_q <= 1'b0;
            end
        end else if (cap_i) begin
            valid_q <= 1'b1;
            value_q <= time_i;
        end
    end

    assign valid_o = valid_q;
    assign value_o = value_q;

endmodule

// File: rtl/ts_slot_alloc.sv
`timescale 1ns/1ps
// Module: lowest-index free slot picker.
// Pure combinational; reports all-ones index and found=0 when nothing is free.
// Assumes IDX_W is wide enough that all-ones is not a legal slot index.
module ts_slot_alloc #(
    parameter int N     = 4,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     free_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);

    // Priority scan: highest index first so the lowest free one wins last
    always_comb begin
        found_o = 1'b0;
        idx_o   = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ts_drop_ctr.sv
`timescale 1ns/1ps
// Module: saturating event counter for receive events that found no slot.
// Holds at all-ones; cleared only by reset.
module ts_drop_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] count_q;

    // Count up on each drop until the maximum value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc_i && (count_q != '1)) begin
            count_q <= count_q + W'(1);
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/ts_read_mux.sv
`timescale 1ns/1ps
// Module: word read multiplexer over the transmit register, status word
// and receive slots. Combinational; returns 0 when idle or unmapped.
// Assumes TIME_W == 2*WORD_W.
module ts_read_mux
    import ts_cap_pkg::*;
#(
    parameter int RX_SLOTS = 4,
    parameter int TIME_W   = 64,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic                       rd_en_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    input  logic [TIME_W-1:0]          tx_value_i,
    input  logic [RX_SLOTS*TIME_W-1:0] rx_values_i,
    input  logic [WORD_W-1:0]          status_i,
    output logic [WORD_W-1:0]          data_o
);

    // Address decode and word select
    always_comb begin
        data_o = '0;
        if (rd_en_i) begin
            if (rd_addr_i == ADDR_W'(ADDR_TX_LO)) begin
                data_o = tx_value_i[WORD_W-1:0];
            end else if (rd_addr_i == ADDR_W'(ADDR_TX_HI)) begin
                data_o = tx_value_i[TIME_W-1:WORD_W];
            end else if (rd_addr_i == ADDR_W'(ADDR_STATUS)) begin
                data_o = status_i;
            end
            for (int i = 0; i < RX_SLOTS; i++) begin
                if (rd_addr_i == ADDR_W'(rx_lo_addr(i))) begin
                    data_o = rx_values_i[i*TIME_W +: WORD_W];
                end else if (rd_addr_i == ADDR_W'(rx_hi_addr(i))) begin
                    data_o = rx_values_i[i*TIME_W+WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/ts_capture_slots.sv
`timescale 1ns/1ps
// Module: packet timestamp capture top.
// One transmit register and RX_SLOTS receive slots, each locked from capture
// until its high word is read. Receive events take the lowest free slot,
// whose index is reported in the event cycle; with no free slot the index is
// all-ones and a saturating drop counter increments. Occupancy seen by an
// event is the value before any release in the same cycle.
// Assumes TIME_W == 2*WORD_W and STAT_DROP_LSB + DROP_W <= WORD_W.
module ts_capture_slots
    import ts_cap_pkg::*;
#(
    parameter  int RX_SLOTS = 4,
    parameter  int TIME_W   = 64,
    parameter  int WORD_W   = 32,
    parameter  int DROP_W   = 8,
    localparam int IDX_W    = $clog2(RX_SLOTS) + 1,
    localparam int ADDR_W   = $clog2(ADDR_RX0 + 2 * RX_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TIME_W-1:0]   time_ns,
    input  logic                tx_event,
    input  logic                rx_event,
    input  logic                irq_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic [IDX_W-1:0]    rx_slot_idx,
    output logic                rx_idx_valid,
    output logic                tx_irq,
    output logic [RX_SLOTS-1:0] rx_status,
    output logic                tx_status,
    output logic [DROP_W-1:0]   drop_count
);

    logic [RX_SLOTS-1:0]        rx_valid;
    logic [RX_SLOTS-1:0]        rx_cap;
    logic [RX_SLOTS-1:0]        rx_rel;
    logic [RX_SLOTS*TIME_W-1:0] rx_values;
    logic [IDX_W-1:0]           grant_idx;
    logic                       grant_ok;
    logic                       tx_valid;
    logic                       tx_rel;
    logic [TIME_W-1:0]          tx_value;
    logic [DROP_W-1:0]          drops;
    logic [WORD_W-1:0]          status_word;

    // Slot allocation over the current (pre-release) occupancy
    ts_slot_alloc #(
        .N     (RX_SLOTS),
        .IDX_W (IDX_W)
    ) u_alloc (
        .free_i  (~rx_valid),
        .idx_o   (grant_idx),
        .found_o (grant_ok)
    );

    // Receive slots with per-slot grant and high-word release decode
    for (genvar g = 0; g < RX_SLOTS; g++) begin : g_rx
        assign rx_cap[g] = rx_event && grant_ok && (grant_idx == IDX_W'(g));
        assign rx_rel[g] = rd_en && (rd_addr == ADDR_W'(rx_hi_addr(g)));

        ts_slot #(
            .TIME_W (TIME_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_i   (rx_cap[g]),
            .rel_i   (rx_rel[g]),
            .time_i  (time_ns),
            .valid_o (rx_valid[g]),
            .value_o (rx_values[g*TIME_W +: TIME_W])
        );
    end

    // Transmit capture register, released by its high-word read
    assign tx_rel = rd_en && (rd_addr == ADDR_W'(ADDR_TX_HI));

    ts_slot #(
        .TIME_W (TIME_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (tx_event),
        .rel_i   (tx_rel),
        .time_i  (time_ns),
        .valid_o (tx_valid),
        .value_o (tx_value)
    );

    // Drop counter for receive events that found every slot full
    ts_drop_ctr #(
        .W (DROP_W)
    ) u_drop (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (rx_event && !grant_ok),
        .count_o (drops)
    );

    // Read-only status word assembly
    always_comb begin
        status_word = '0;
        status_word[RX_SLOTS-1:0] = rx_valid;
        status_word[STAT_TX_BIT] = tx_valid;
        status_word[STAT_DROP_LSB +: DROP_W] = drops;
    end

    // Software read port
    ts_read_mux #(
        .RX_SLOTS (RX_SLOTS),
        .TIME_W   (TIME_W),
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W)
    ) u_rmux (
        .rd_en_i     (rd_en),
        .rd_addr_i   (rd_addr),
        .tx_value_i  (tx_value),
        .rx_values_i (rx_values),
        .status_i    (status_word),
        .data_o      (rd_data)
    );

    // Event-cycle index report and output flags
    assign rx_idx_valid = rx_event && grant_ok;
    assign rx_slot_idx  = rx_idx_valid ? grant_idx : '1;
    assign tx_irq       = irq_en && tx_valid;
    assign rx_status    = rx_valid;
    assign tx_status    = tx_valid;
    assign drop_count   = drops;

endmodule

// File: rtl/ts_capture_slots_chk.sv
`timescale 1ns/1ps
// Module: property checker for the capture block, bound to every instance.
// Observes ports only; assumes the read map of ts_cap_pkg.
module ts_capture_slots_chk
    import ts_cap_pkg::*;
#(
    parameter  int RX_SLOTS = 4,
    parameter  int DROP_W   = 8,
    localparam int IDX_W    = $clog2(RX_SLOTS) + 1,
    localparam int ADDR_W   = $clog2(ADDR_RX0 + 2 * RX_SLOTS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_event,
    input logic                rx_event,
    input logic                irq_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [IDX_W-1:0]    rx_slot_idx,
    input logic                rx_idx_valid,
    input logic                tx_irq,
    input logic [RX_SLOTS-1:0] rx_status,
    input logic                tx_status,
    input logic [DROP_W-1:0]   drop_count
);

    // R2
    granted_slot_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idx_valid |=> rx_status[$past(rx_slot_idx[IDX_W-2:0])]);

    // R2
    granted_slot_was_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idx_valid |-> !rx_status[rx_slot_idx[IDX_W-2:0]]);

    // R5
    full_means_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_event && (&rx_status)) |-> (!rx_idx_valid && (&rx_slot_idx)));

    // R5
    drop_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&drop_count) |=> (&drop_count));

    // R7
    tx_lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_status && !(rd_en && rd_addr == ADDR_W'(ADDR_TX_HI))) |=> tx_status);

    // R6
    tx_capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_event && !tx_status) |=> tx_status);

    // R9
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_status && irq_en));

    // R11
    status_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(ADDR_STATUS) && !rx_event) |=> $stable(rx_status));

    for (genvar g = 0; g < RX_SLOTS; g++) begin : g_rel
        // R4
        hi_read_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == ADDR_W'(rx_hi_addr(g)) && rx_status[g]) |=> !rx_status[g]);
    end

    // R8
    tx_hi_read_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(ADDR_TX_HI) && tx_status) |=> !tx_status);

endmodule

bind ts_capture_slots ts_capture_slots_chk #(
    .RX_SLOTS (RX_SLOTS),
    .DROP_W   (DROP_W)
) u_chk (.*);

// File: tb/test_ts_capture_slots.sv
`timescale 1ns/1ps
// Bench: vector table for allocation/status, then directed corner tests.
module test_ts_capture_slots;

    localparam int RX_SLOTS = 4;
    localparam int TIME_W   = 64;
    localparam int WORD_W   = 32;
    localparam int DROP_W   = 8;
    localparam int IDX_W    = 3;
    localparam int ADDR_W   = 4;
    localparam int NVEC     = 18;

    // Table entry: {op[3:0], addr[7:0], expected[31:0]}
    // op 0: receive event, expect index; op 1: read, expect data; op 2: read, no check
    localparam logic [43:0] VEC [NVEC] = '{
        {4'd0, 8'd0,  32'h0},      // R2 first event -> slot 0
        {4'd0, 8'd0,  32'h1},      // R2 next -> slot 1
        {4'd1, 8'd2,  32'h3},      // R3 status flags
        {4'd0, 8'd0,  32'h2},      // R2
        {4'd0, 8'd0,  32'h3},      // R2
        {4'd1, 8'd2,  32'hF},      // R3 all full
        {4'd0, 8'd0,  32'h7},      // R5 full -> invalid index
        {4'd1, 8'd2,  32'h1000F},  // R3 R5 drop count field
        {4'd2, 8'd7,  32'h0},      // release slot 1
        {4'd1, 8'd2,  32'h1000D},  // R4 slot 1 freed
        {4'd0, 8'd0,  32'h1},      // R2 lowest free reused
        {4'd2, 8'd4,  32'h0},      // low read of slot 0
        {4'd1, 8'd2,  32'h1000F},  // R4 low read keeps lock
        {4'd2, 8'd5,  32'h0},
        {4'd2, 8'd7,  32'h0},
        {4'd2, 8'd9,  32'h0},
        {4'd2, 8'd11, 32'h0},
        {4'd1, 8'd2,  32'h10000}   // R4 all freed
    };

    logic                clk = 1'b0;
    logic                rst_n;
    logic [TIME_W-1:0]   time_ns = 64'h0123_4567_89AB_0000;
    logic                tx_event, rx_event, irq_en, rd_en;
    logic [ADDR_W-1:0]   rd_addr;
    logic [WORD_W-1:0]   rd_data;
    logic [IDX_W-1:0]    rx_slot_idx;
    logic                rx_idx_valid, tx_irq, tx_status;
    logic [RX_SLOTS-1:0] rx_status;
    logic [DROP_W-1:0]   drop_count;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Running time; the high word moves every cycle
    always @(negedge clk) time_ns <= time_ns + 64'h0000_0001_0000_0007;

    ts_capture_slots i_ts_capture_slots (
        .clk, .rst_n, .time_ns, .tx_event, .rx_event, .irq_en, .rd_en, .rd_addr,
        .rd_data, .rx_slot_idx, .rx_idx_valid, .tx_irq, .rx_status, .tx_status,
        .drop_count
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_rx(output logic [IDX_W-1:0] idx, output logic v, output logic [63:0] t);
        rx_event = 1'b1;
        #1;
        idx = rx_slot_idx; v = rx_idx_valid; t = time_ns;
        @(negedge clk);
        rx_event = 1'b0;
        #1;
    endtask

    task automatic do_tx(output logic [63:0] t);
        tx_event = 1'b1;
        #1;
        t = time_ns;
        @(negedge clk);
        tx_event = 1'b0;
        #1;
    endtask

    task automatic do_rd(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
        rd_en = 1'b1; rd_addr = a;
        #1;
        d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = '0;
        #1;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [IDX_W-1:0]  idx;
        logic              v;
        logic [63:0]       t0, t1, t2;
        logic [WORD_W-1:0] lo, hi, d;
        int                exp_drop;

        rst_n = 1'b0; tx_event = 0; rx_event = 0; irq_en = 1'b1; rd_en = 0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 rx_status", 64'(rx_status), 64'h0);
        check("R1 tx_status", 64'(tx_status), 64'h0);
        check("R1 drop", 64'(drop_count), 64'h0);
        check("R1 irq", 64'(tx_irq), 64'h0);
        do_rd(4'd2, d);
        check("R1 status word", 64'(d), 64'h0);

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][43:40] == 4'd0) begin
                do_rx(idx, v, t0);
                check($sformatf("R2/R5 vec%0d idx", k), 64'(idx), 64'(VEC[k][31:0]));
                check($sformatf("R2/R5 vec%0d valid", k), 64'(v), 64'(VEC[k][31:0] != 32'h7));
            end else begin
                do_rd(VEC[k][ADDR_W-1+32:32], d);
                if (VEC[k][43:40] == 4'd1)
                    check($sformatf("R3/R4 vec%0d data", k), 64'(d), 64'(VEC[k][31:0]));
            end
        end
        exp_drop = 1;

        // R10 coherent value across a split read
        do_rx(idx, v, t0);
        check("R2 idx after free", 64'(idx), 64'h0);
        do_rd(4'd4, lo);
        repeat (3) @(negedge clk);
        #1;
        do_rd(4'd5, hi);
        check("R10 rx value", {hi, lo}, t0);

        // R6 / R9 transmit capture and interrupt
        do_tx(t1);
        check("R6 tx_status", 64'(tx_status), 64'h1);
        check("R9 irq on", 64'(tx_irq), 64'h1);
        irq_en = 1'b0;
        #1;
        check("R9 irq gated", 64'(tx_irq), 64'h0);
        irq_en = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        // R7 second event while locked
        do_tx(t2);
        do_rd(4'd0, lo);
        check("R8 low read keeps lock", 64'(tx_status), 64'h1);
        do_rd(4'd1, hi);
        check("R7 held value", {hi, lo}, t1);
        check("R8 hi read frees", 64'(tx_status), 64'h0);
        check("R9 irq off", 64'(tx_irq), 64'h0);

        // R11 status reads leave slots locked
        for (int k = 0; k < RX_SLOTS; k++) do_rx(idx, v, t0);
        repeat (3) do_rd(4'd2, d);
        check("R11 flags kept", 64'(rx_status), 64'hF);

        // R12 release and event in the same cycle
        rx_event = 1'b1; rd_en = 1'b1; rd_addr = 4'd9;
        #1;
        check("R12 idx", 64'(rx_slot_idx), 64'h7);
        check("R12 valid", 64'(rx_idx_valid), 64'h0);
        @(negedge clk);
        rx_event = 1'b0; rd_en = 1'b0; rd_addr = '0;
        #1;
        exp_drop++;
        check("R12 slot2 free", 64'(rx_status), 64'hB);
        check("R12 drop", 64'(drop_count), 64'(exp_drop));
        do_rx(idx, v, t0);
        check("R12 reuse slot2", 64'(idx), 64'h2);

        // R5 saturation with all slots full
        repeat (300) do_rx(idx, v, t0);
        check("R5 saturate", 64'(drop_count), 64'hFF);
        check("R5 slots unchanged", 64'(rx_status), 64'hF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule